// File: doc/BRIEF.md
# Bus-Mastering Thermal Sensor Sequencer

This block gathers temperature-sensor voltages without owning a converter. It acts as a bus master towards a shared ADC and an analog sensor multiplexer. For every enabled sensor slot it performs the following steps:

- optionally writes the slot's mux code to the sensor-mux register;
- optionally writes a channel code to the ADC mux register;
- writes an enable word to start a conversion;
- polls a status address until a configurable valid bit shows the wanted level;
- keeps the shifted voltage field in a per-slot result register.

Every bus address and data word comes from software-programmed registers, so one design can serve converters mapped at any address.

Pacing comes from a time unit. One unit lasts max(unit,1)·2^UNIT_SHIFT bus clocks. A sensor interval, counted in units, separates measurement rounds. A filter interval, also in units, separates slots inside one round. A poll interval, in clocks, spaces the status polls. A poll limit stops polling of a converter that never answers, and raises a sticky flag when it does.

Top module: `thermal_seq`

## Requirements
- R1: After reset every register reads 0, every result has its updated flag clear, and no bus request is raised while the slot mask is 0.
- R2: A round visits only the slots whose bit is set in the slot mask (offset 0x00, bit i = slot i), in ascending slot order. A disabled slot's updated flag stays clear. The slot mux codes sit at 0x40+4·i.
- R3: Write-control (0x14): bit0 enables the sensor-mux write and bit1 enables the ADC-mux write. A transaction whose bit is 0 is skipped, so the slot starts with the next step.
- R4: For each slot the bus sees, in this order:
  - a write of the slot mux code to the sensor-mux address (0x24);
  - a write of the ADC-mux value (0x2C) to the ADC-mux address (0x28);
  - a write of the enable value (0x34) to the enable address (0x30);
  - reads of the valid address (0x38).
- R5: Valid-mask (0x18): bits 4:0 give the valid-bit position, and bit 5 = 1 means the bit is valid when 1 (0: valid when 0). Polling repeats until the bit is valid.
- R6: Read-control (0x20) bit0 = 0 takes the voltage from the polling read itself. Bit0 = 1 adds one read of the voltage address (0x3C) after the valid poll and takes the voltage from that read.
- R7: Poll limit (0x10) = N:
  - after N failed polls of a slot, status (0x70) bit0 is set, nothing is stored, and the round moves to the next slot;
  - 0 acts as 1;
  - 0xFFFFFFFF never times out.
  - Reading the status register clears the flag.
- R8: The result at 0x60+4·i holds the read data right-shifted by the shift register (0x1C, bits 4:0), masked to 12 bits in bits 11:0, with an updated flag in bit 31. Reading the result clears that flag.
- R9: The poll interval (0x0C, clocks) is waited between a failed poll's response and the next poll request.
- R10: The time unit (0x04, bits 9:0) lasts max(unit,1)·2^UNIT_SHIFT clocks. The first round starts as soon as the mask is non-zero. Later rounds start after a wait of the sensor interval (0x08 bits 9:0) in units.
- R11: Between consecutive slots of a round the block waits the filter interval (0x08 bits 25:16) in units.
- R12: At most one bus transaction is outstanding. While waiting for grant, the request, address, direction and write data stay stable. A write completes on a write acknowledge and a read on read-data-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears read-sensitive flags) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| m_req | output | 1 | Bus master request |
| m_we | output | 1 | 1 = write, 0 = read |
| m_addr | output | AW | Bus address |
| m_wdata | output | 32 | Bus write data |
| m_gnt | input | 1 | Grant for the pending request |
| m_wack | input | 1 | Write completion |
| m_rvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |

## Verification
The hardest state to reach from the ports is a slot that has polled many times without seeing its valid bit, either running up to the poll limit or continuing without bound. The bench model of the converter counts polls after each enable write and reports the valid level only after a programmed number of polls. This makes it possible to drive exact limit counts, a limit of zero, the unlimited setting, and a round that must abandon one slot and continue with the next. Sweeps over every slot mask vary the valid-bit position, polarity, shift and grant latency together, and the expected codes are computed from the model's word formula.

// File: rtl/thermal_seq.sv
module thermal_seq #(
  parameter int NSLOT      = 4,
  parameter int AW         = 32,
  parameter int UNIT_SHIFT = 8,
  parameter int MW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic          m_gnt,
  input  logic          m_wack,
  input  logic          m_rvalid,
  input  logic [31:0]   m_rdata
);
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int PW = 10 + UNIT_SHIFT;

  typedef enum logic [3:0] {S_IDLE, S_SMUX, S_AMUX, S_EN, S_POLL, S_PWAIT, S_VREAD, S_FILT, S_SEN} st_t;

  logic [NSLOT-1:0] en_mask, rmask, meas_u;
  logic [9:0]  unit, sen_iv, flt_iv;
  logic [15:0] poll_iv;
  logic [31:0] tmo;
  logic [1:0]  wctl;
  logic [4:0]  vpos, vshift;
  logic        vhigh, sep_rd, tmo_flag;
  logic [AW-1:0] a_smux, a_amux, a_en, a_valid, a_volt;
  logic [31:0] d_amux, d_en;
  logic [31:0] mux_val [NSLOT];
  logic [MW-1:0] meas_d [NSLOT];

  st_t state;
  logic [SW-1:0] cur;
  logic          issued;
  logic [31:0]   pcnt;
  logic [15:0]   wcnt;
  logic [PW-1:0] pre;

  function automatic logic [SW:0] pick(input logic [NSLOT-1:0] m, input int from);
    pick = '0;
    for (int i = NSLOT-1; i >= 0; i--)
      if (i >= from && m[i]) pick = {1'b1, SW'(i)};
  endfunction

  function automatic st_t slot_start(input logic [1:0] w);
    slot_start = w[0] ? S_SMUX : (w[1] ? S_AMUX : S_EN);
  endfunction

  logic [SW:0]   nx, first;
  logic [PW-1:0] per;
  logic [31:0]   lim, shifted;
  logic          tick, done, seen, expire, store;

  assign nx      = pick(rmask, int'(cur) + 1);
  assign first   = pick(en_mask, 0);
  assign per     = PW'(unit == 10'd0 ? 10'd1 : unit) << UNIT_SHIFT;
  assign tick    = (pre == per - 1'b1);
  assign lim     = (tmo == 32'd0) ? 32'd1 : tmo;
  assign done    = issued && (m_we ? m_wack : m_rvalid);
  assign seen    = vhigh ? m_rdata[vpos] : ~m_rdata[vpos];
  assign expire  = (tmo != '1) && (pcnt + 32'd1 >= lim);
  assign shifted = m_rdata >> vshift;
  assign store   = done && ((state == S_POLL && seen && !sep_rd) || state == S_VREAD);

  assign m_req = !issued && (state inside {S_SMUX, S_AMUX, S_EN, S_POLL, S_VREAD});
  assign m_we  = state inside {S_SMUX, S_AMUX, S_EN};

  always_comb begin
    m_addr  = a_valid;
    m_wdata = '0;
    case (state)
      S_SMUX:  begin m_addr = a_smux; m_wdata = mux_val[cur]; end
      S_AMUX:  begin m_addr = a_amux; m_wdata = d_amux; end
      S_EN:    begin m_addr = a_en;   m_wdata = d_en; end
      S_VREAD: m_addr = a_volt;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_mask <= '0; unit <= '0; sen_iv <= '0; flt_iv <= '0; poll_iv <= '0; tmo <= '0;
      wctl <= '0; vpos <= '0; vhigh <= 1'b0; vshift <= '0; sep_rd <= 1'b0;
      a_smux <= '0; a_amux <= '0; a_en <= '0; a_valid <= '0; a_volt <= '0;
      d_amux <= '0; d_en <= '0;
      for (int i = 0; i < NSLOT; i++) mux_val[i] <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        8'h00: en_mask <= reg_wdata[NSLOT-1:0];
        8'h04: unit    <= reg_wdata[9:0];
        8'h08: begin sen_iv <= reg_wdata[9:0]; flt_iv <= reg_wdata[25:16]; end
        8'h0C: poll_iv <= reg_wdata[15:0];
        8'h10: tmo     <= reg_wdata;
        8'h14: wctl    <= reg_wdata[1:0];
        8'h18: begin vpos <= reg_wdata[4:0]; vhigh <= reg_wdata[5]; end
        8'h1C: vshift  <= reg_wdata[4:0];
        8'h20: sep_rd  <= reg_wdata[0];
        8'h24: a_smux  <= reg_wdata[AW-1:0];
        8'h28: a_amux  <= reg_wdata[AW-1:0];
        8'h2C: d_amux  <= reg_wdata;
        8'h30: a_en    <= reg_wdata[AW-1:0];
        8'h34: d_en    <= reg_wdata;
        8'h38: a_valid <= reg_wdata[AW-1:0];
        8'h3C: a_volt  <= reg_wdata[AW-1:0];
        default: ;
      endcase
      for (int i = 0; i < NSLOT; i++)
        if (reg_addr == 8'(8'h40 + 4*i)) mux_val[i] <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      8'h00: reg_rdata = 32'(en_mask);
      8'h04: reg_rdata = 32'(unit);
      8'h08: reg_rdata = {6'd0, flt_iv, 6'd0, sen_iv};
      8'h0C: reg_rdata = 32'(poll_iv);
      8'h10: reg_rdata = tmo;
      8'h14: reg_rdata = 32'(wctl);
      8'h18: reg_rdata = {26'd0, vhigh, vpos};
      8'h1C: reg_rdata = 32'(vshift);
      8'h20: reg_rdata = 32'(sep_rd);
      8'h24: reg_rdata = 32'(a_smux);
      8'h28: reg_rdata = 32'(a_amux);
      8'h2C: reg_rdata = d_amux;
      8'h30: reg_rdata = 32'(a_en);
      8'h34: reg_rdata = d_en;
      8'h38: reg_rdata = 32'(a_valid);
      8'h3C: reg_rdata = 32'(a_volt);
      8'h70: reg_rdata = 32'(tmo_flag);
      default: ;
    endcase
    for (int i = 0; i < NSLOT; i++) begin
      if (reg_addr == 8'(8'h40 + 4*i)) reg_rdata = mux_val[i];
      if (reg_addr == 8'(8'h60 + 4*i)) reg_rdata = {meas_u[i], {(31-MW){1'b0}}, meas_d[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_u <= '0;
      for (int i = 0; i < NSLOT; i++) meas_d[i] <= '0;
    end else begin
      for (int i = 0; i < NSLOT; i++) begin
        if (reg_re && reg_addr == 8'(8'h60 + 4*i)) meas_u[i] <= 1'b0;
        if (store && cur == SW'(i)) begin
          meas_u[i] <= 1'b1;
          meas_d[i] <= shifted[MW-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; cur <= '0; rmask <= '0; issued <= 1'b0;
      pcnt <= '0; wcnt <= '0; pre <= '0; tmo_flag <= 1'b0;
    end else begin
      if (reg_re && reg_addr == 8'h70) tmo_flag <= 1'b0;
      if (m_req && m_gnt) issued <= 1'b1;
      else if (done)      issued <= 1'b0;
      case (state)
        S_IDLE, S_SEN: begin
          if (en_mask == '0) state <= S_IDLE;
          else if (state == S_IDLE || wcnt == '0) begin
            rmask <= en_mask;
            cur   <= first[SW-1:0];
            state <= slot_start(wctl);
          end else if (tick) begin wcnt <= wcnt - 1'b1; pre <= '0; end
          else pre <= pre + 1'b1;
        end
        S_FILT: begin
          if (wcnt == '0) state <= slot_start(wctl);
          else if (tick) begin wcnt <= wcnt - 1'b1; pre <= '0; end
          else pre <= pre + 1'b1;
        end
        S_SMUX: if (done) state <= wctl[1] ? S_AMUX : S_EN;
        S_AMUX: if (done) state <= S_EN;
        S_EN:   if (done) begin state <= S_POLL; pcnt <= '0; end
        S_PWAIT: begin
          if (wcnt == '0) state <= S_POLL;
          else wcnt <= wcnt - 1'b1;
        end
        S_POLL, S_VREAD: if (done) begin
          if (state == S_POLL && seen && sep_rd) state <= S_VREAD;
          else if (state == S_POLL && !seen && !expire) begin
            pcnt  <= pcnt + 32'd1;
            wcnt  <= poll_iv;
            state <= S_PWAIT;
          end else begin
            if (state == S_POLL && !seen) tmo_flag <= 1'b1;
            pre <= '0;
            if (nx[SW]) begin
              cur <= nx[SW-1:0]; wcnt <= 16'(flt_iv); state <= S_FILT;
            end else begin
              wcnt <= 16'(sen_iv); state <= S_SEN;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r12_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  a_r7_poll_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL && tmo != '1) |-> (pcnt < lim));

  a_r2_store_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    store |-> rmask[cur]);

  a_r12_no_response_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !issued);

  for (genvar g = 0; g < NSLOT; g++) begin : g_clr
    a_r8_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && reg_addr == 8'(8'h60 + 4*g) && !(store && cur == SW'(g))) |=> !meas_u[g]);
  end
endmodule

// File: tb/tb_thermal_seq.sv
module tb_thermal_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, reg_we, reg_re;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic m_req, m_we, m_gnt, m_wack, m_rvalid;
  logic [31:0] m_addr, m_wdata, m_rdata;

  thermal_seq #(.NSLOT(4), .AW(32), .UNIT_SHIFT(0), .MW(12)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_gnt(m_gnt), .m_wack(m_wack),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata));

  localparam logic [31:0] A_SMUX = 32'h1000_0604, A_AMUX = 32'h2000_000C,
                          A_EN = 32'h2000_0008, A_VALID = 32'h2000_0040, A_VOLT2 = 32'h2000_0044;
  logic [31:0] a_volt_cur;

  int nchk = 0, nfail = 0;
  int need = 0, polls = 0, sh_t = 0, pos_t = 12, gdelay = 0, gw = 0, viol = 0;
  bit hi_t = 1;
  logic [31:0] cur_mux = 0, held, prd;
  bit pend = 0, pwe = 0;

  logic [31:0] la [0:1023];
  logic [31:0] ld [0:1023];
  bit lw [0:1023];
  int lt [0:1023];
  int nt = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] vword(input logic [31:0] mux, input bit valid);
    logic [31:0] w;
    w = ((mux * 37 + 5) & 32'hFFF) << sh_t;
    w[pos_t] = valid ? hi_t : !hi_t;
    return w;
  endfunction
  function automatic logic [31:0] sword(input logic [31:0] mux);
    return ((mux * 53 + 9) & 32'hFFF) << sh_t;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    m_gnt = 0; m_wack = 0; m_rvalid = 0; m_rdata = 0;
    forever begin
      @(negedge clk);
      m_gnt = 0; m_wack = 0; m_rvalid = 0;
      if (pend) begin
        if (m_req) viol++;
        if (pwe) m_wack = 1; else begin m_rvalid = 1; m_rdata = prd; end
        pend = 0;
      end else if (rst_n && m_req) begin
        if (gw < gdelay) begin
          if (gw > 0 && m_addr != held) viol++;
          held = m_addr; gw++;
        end else begin
          if (gw > 0 && m_addr != held) viol++;
          gw = 0; m_gnt = 1; pend = 1; pwe = m_we;
          if (nt < 1024) begin la[nt] = m_addr; ld[nt] = m_wdata; lw[nt] = m_we; lt[nt] = cyc; nt++; end
          if (m_we) begin
            if (m_addr == A_SMUX) cur_mux = m_wdata;
            if (m_addr == A_EN) polls = 0;
          end else if (m_addr == A_VALID) begin
            polls++; prd = vword(cur_mux, polls > need);
          end else if (m_addr == a_volt_cur) prd = sword(cur_mux);
          else prd = 32'hDEAD_BEEF;
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask
  task automatic run(input logic [3:0] mask, input int n);
    nt = 0; wr(8'h00, 32'(mask)); repeat (n) @(negedge clk); wr(8'h00, 0); repeat (6) @(negedge clk);
  endtask
  task automatic count(input logic [31:0] a, input bit we, output int c);
    c = 0;
    for (int i = 0; i < nt; i++) if (la[i] == a && lw[i] == we) c++;
  endtask
  task automatic finish_all;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_all();
  end

  initial begin
    logic [31:0] d;
    int c, c2, g0, g1;
    rst_n = 0; reg_we = 0; reg_re = 0; reg_addr = 0; reg_wdata = 0; a_volt_cur = A_VALID;
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(8'h08, d); chk(d == 0, "R1 interval reg reset", d, 0);
    rd(8'h10, d); chk(d == 0, "R1 limit reg reset", d, 0);
    rd(8'h60, d); chk(d == 0, "R1 result reset", d, 0);
    rd(8'h6C, d); chk(d == 0, "R1 result3 reset", d, 0);
    rd(8'h70, d); chk(d == 0, "R1 status reset", d, 0);
    repeat (5) @(negedge clk);
    chk(m_req == 0, "R1 no request idle", m_req, 0);

    wr(8'h04, 1); wr(8'h08, 1000); wr(8'h0C, 1); wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 3);
    wr(8'h18, 32'h20 | 12); wr(8'h1C, 0); wr(8'h20, 0);
    wr(8'h24, A_SMUX); wr(8'h28, A_AMUX); wr(8'h2C, 32'h800); wr(8'h30, A_EN); wr(8'h34, 32'h801);
    wr(8'h38, A_VALID); wr(8'h3C, A_VALID);
    for (int i = 0; i < 4; i++) wr(8'(8'h40 + 4*i), 32'h10 + i);

    need = 2; run(4'b0001, 200);
    chk(nt == 6, "R4 transaction count", nt, 6);
    chk(lw[0] && la[0] == A_SMUX && ld[0] == 32'h10, "R4 sensor mux write", la[0], A_SMUX);
    chk(lw[1] && la[1] == A_AMUX && ld[1] == 32'h800, "R4 adc mux write", la[1], A_AMUX);
    chk(lw[2] && la[2] == A_EN && ld[2] == 32'h801, "R4 enable write", la[2], A_EN);
    chk(!lw[3] && la[3] == A_VALID && !lw[5] && la[5] == A_VALID, "R4 polls valid address", la[5], A_VALID);
    rd(8'h60, d);
    chk(d == {1'b1, 19'd0, vword(32'h10, 1)[11:0]}, "R8 stored value", d, {1'b1, 19'd0, vword(32'h10, 1)[11:0]});
    rd(8'h60, d); chk(d[31] == 0, "R8 read clears updated flag", d[31], 0);

    for (int m = 1; m < 16; m++) begin
      int exp_n, k;
      logic [31:0] mv [4];
      sh_t = m % 5; pos_t = (m % 4 == 0) ? 12 : (m % 4 == 1) ? 17 : (m % 4 == 2) ? 24 : 31;
      hi_t = m[0]; need = m % 3; gdelay = (m % 2) * 2;
      wr(8'h18, (hi_t ? 32'h20 : 0) | 32'(pos_t)); wr(8'h1C, 32'(sh_t));
      for (int i = 0; i < 4; i++) begin
        mv[i] = 32'h100 + 32'(i * 7 + m * 3); wr(8'(8'h40 + 4*i), mv[i]); rd(8'(8'h60 + 4*i), d);
      end
      run(4'(m), 400);
      exp_n = 0; k = 0;
      for (int i = 0; i < 4; i++) if (m[i]) exp_n++;
      count(A_SMUX, 1, c);
      chk(c == exp_n, "R2 one round visits enabled slots", c, exp_n);
      count(A_VALID, 0, c);
      chk(c == exp_n * (need + 1), "R5 polls until valid", c, exp_n * (need + 1));
      for (int i = 0; i < nt; i++) if (lw[i] && la[i] == A_SMUX) begin
        while (k < 4 && !m[k]) k++;
        chk(k < 4 && ld[i] == mv[k], "R2 ascending slot order", ld[i], k < 4 ? mv[k] : 0);
        k++;
      end
      for (int i = 0; i < 4; i++) begin
        rd(8'(8'h60 + 4*i), d);
        if (m[i]) chk(d == {1'b1, 19'd0, 12'((vword(mv[i], 1) >> sh_t) & 32'hFFF)}, "R8 shifted masked result",
                      d, {1'b1, 19'd0, 12'((vword(mv[i], 1) >> sh_t) & 32'hFFF)});
        else chk(d[31] == 0, "R2 disabled slot untouched", d[31], 0);
      end
    end
    gdelay = 0; sh_t = 0; pos_t = 12; hi_t = 1; wr(8'h18, 32'h20 | 12); wr(8'h1C, 0);
    chk(viol == 0, "R12 single outstanding and stable request", viol, 0);

    need = 0; wr(8'h14, 0); run(4'b0001, 150);
    chk(lw[0] && la[0] == A_EN, "R3 both mux writes skipped", la[0], A_EN);
    wr(8'h14, 2); run(4'b0001, 150);
    count(A_SMUX, 1, c);
    chk(la[0] == A_AMUX && c == 0, "R3 sensor mux write skipped", la[0], A_AMUX);
    wr(8'h14, 1); run(4'b0001, 150);
    count(A_AMUX, 1, c);
    chk(la[0] == A_SMUX && la[1] == A_EN && c == 0, "R3 adc mux write skipped", la[1], A_EN);
    wr(8'h14, 3);

    a_volt_cur = A_VOLT2; wr(8'h3C, A_VOLT2); wr(8'h20, 1); wr(8'h40, 32'h55); need = 1;
    run(4'b0001, 200);
    chk(nt == 6 && !lw[5] && la[5] == A_VOLT2, "R6 separate voltage read", la[5], A_VOLT2);
    rd(8'h60, d);
    chk(d == {1'b1, 19'd0, sword(32'h55)[11:0]}, "R6 voltage from second read", d, {1'b1, 19'd0, sword(32'h55)[11:0]});
    wr(8'h20, 0); wr(8'h3C, A_VALID); a_volt_cur = A_VALID;

    need = 1000000; wr(8'h10, 3); rd(8'h60, d); rd(8'h64, d);
    run(4'b0011, 200);
    count(A_VALID, 0, c); count(A_EN, 1, c2);
    chk(c == 6, "R7 limit stops polling", c, 6);
    chk(c2 == 2, "R7 round moves to next slot", c2, 2);
    rd(8'h60, d); chk(d[31] == 0, "R7 no store on timeout", d[31], 0);
    rd(8'h70, d); chk(d[0] == 1, "R7 timeout flag set", d[0], 1);
    rd(8'h70, d); chk(d[0] == 0, "R7 status read clears flag", d[0], 0);
    wr(8'h10, 0); run(4'b0001, 100);
    count(A_VALID, 0, c); chk(c == 1, "R7 zero limit acts as one", c, 1);
    rd(8'h70, d);
    need = 40; wr(8'h10, 32'hFFFF_FFFF); wr(8'h0C, 0); run(4'b0001, 500);
    count(A_VALID, 0, c); chk(c == 41, "R7 unlimited polling", c, 41);
    rd(8'h70, d); chk(d[0] == 0, "R7 unlimited no timeout", d[0], 0);
    rd(8'h60, d); chk(d[31] == 1, "R7 unlimited stores", d[31], 1);

    need = 3; wr(8'h0C, 7); run(4'b0001, 200);
    for (int i = 4; i < 7; i++)
      chk(lt[i] - lt[i-1] >= 7 && lt[i] - lt[i-1] <= 15, "R9 poll spacing", lt[i] - lt[i-1], 7);
    wr(8'h0C, 1);

    need = 0; wr(8'h04, 3); wr(8'h08, 4); run(4'b0001, 200);
    g0 = lt[4] - lt[3];
    chk(la[4] == A_SMUX && g0 >= 12 && g0 <= 20, "R10 sensor interval in units", g0, 12);
    wr(8'h04, 0); run(4'b0001, 200);
    g1 = lt[4] - lt[3];
    chk(g1 >= 4 && g1 <= 12, "R10 zero unit acts as one", g1, 4);
    chk(g0 - g1 == 8, "R10 unit scales wait", g0 - g1, 8);

    wr(8'h04, 2); wr(8'h08, (5 << 16) | 1000); run(4'b0011, 200);
    g0 = lt[4] - lt[3];
    chk(la[4] == A_SMUX && g0 >= 10 && g0 <= 18, "R11 filter interval", g0, 10);
    wr(8'h08, 1000); run(4'b0011, 200);
    g1 = lt[4] - lt[3];
    chk(g0 - g1 == 10, "R11 filter adds units", g0 - g1, 10);

    finish_all();
  end
endmodule